// File: doc/BRIEF.md
# Queue Interrupt Status Aggregator

This block gathers completion and exception events from a set of per-endpoint transmit and receive queue engines into status registers that software reads and clears. Every status bit is set by a one-cycle event pulse, stays set until software writes a one to it, and feeds a single registered interrupt line through a matching enable register.

Completion events share one status word: the transmit side takes the low half and the receive side the high half. Exception events land in three per-endpoint error registers. A read-only summary word carries one bit per exception class. Each summary bit is the OR, over endpoints, of the enabled bits of its error field. The interrupt asserts when any enabled completion bit or any enabled summary bit is set. Endpoint 0 has no queue, so its event inputs are discarded.

Top module: `qirq_aggregator`

## Requirements
- R1: After reset every status, error and enable register reads zero and `irq_o` is low.
- R2: A pulse on `tx_done_i[n]` sets bit n of the completion word (address 0). A pulse on `rx_done_i[n]` sets bit 16+n.
- R3: Writing a status or error register clears each bit written as 1. Bits written as 0 keep their value.
- R4: When an event and a write-one clear hit the same bit in the same cycle, the bit stays set.
- R5: Events on endpoint 0 are ignored. Bit 0 and bit 16 of the completion word and of every error register never set.
- R6: Error register layout. Address 4 holds receive checksum errors in bits 15:0 and receive length errors in bits 31:16. Address 6 holds receive zero-length errors in bits 15:0 and reads zero above. Address 8 holds transmit checksum errors in bits 15:0 and transmit length errors in bits 31:16.
- R7: The summary word (address 2, read-only) has these bits:
  - bit 0: receive checksum
  - bit 1: receive length
  - bit 2: receive zero-length
  - bit 3: transmit checksum
  - bit 4: transmit length

  Each summary bit is set exactly when some endpoint bit of its field is set with its enable bit also set.
- R8: `irq_o` is registered. It rises one cycle after some completion bit and its enable bit (address 1) are both set, or some summary bit and its enable bit (address 3, bits 4:0) are both set. It falls one cycle after no such pair remains.
- R9: The enable registers read back what was written. They sit at addresses 1, 3, 5, 7 and 9, and each guards the register one address below it. Address 3 keeps bits 4:0 and address 7 keeps bits 15:0.
- R10: Status bits set whether or not they are enabled. Enables only gate the summary and the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| tx_done_i | input | 16 | Transmit queue done pulses, one per endpoint |
| rx_done_i | input | 16 | Receive queue done pulses |
| rx_cs_err_i | input | 16 | Receive checksum error pulses |
| rx_len_err_i | input | 16 | Receive length error pulses |
| rx_zlp_err_i | input | 16 | Receive zero-length error pulses |
| tx_cs_err_i | input | 16 | Transmit checksum error pulses |
| tx_len_err_i | input | 16 | Transmit length error pulses |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is an event pulse that lands in the very cycle software clears the same bit. A plain write task cannot do it, because it owns the clock edge alone. A dedicated scenario therefore drives the write strobe and the event pulse on the same falling edge, then reads the bit back. The registered interrupt is also sampled twice around every change: once in the cycle the status word moves, where it must still hold its old value, and once a cycle later.

// File: rtl/qirq_pkg.sv
package qirq_pkg;
  localparam int ADDR_W = 4;
  localparam int SUM_W  = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_DONE    = 4'd0,
    A_DONE_EN = 4'd1,
    A_SUM     = 4'd2,
    A_SUM_EN  = 4'd3,
    A_RXE0    = 4'd4,
    A_RXE0_EN = 4'd5,
    A_RXE1    = 4'd6,
    A_RXE1_EN = 4'd7,
    A_TXE     = 4'd8,
    A_TXE_EN  = 4'd9
  } reg_addr_e;

  // summary bit positions
  localparam int S_RX_CS  = 0;
  localparam int S_RX_LEN = 1;
  localparam int S_RX_ZLP = 2;
  localparam int S_TX_CS  = 3;
  localparam int S_TX_LEN = 4;
endpackage

// File: rtl/qirq_w1c_reg.sv
module qirq_w1c_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;  // set beats clear
  end

  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/qirq_en_reg.sv
module qirq_en_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  p_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/qirq_summary.sv
module qirq_summary
  import qirq_pkg::*;
#(
  parameter int NUM_EP = 16,
  localparam int DW = 2 * NUM_EP
) (
  input  logic [DW-1:0]     rxe0_i,
  input  logic [DW-1:0]     rxe0_en_i,
  input  logic [NUM_EP-1:0] rxe1_i,
  input  logic [NUM_EP-1:0] rxe1_en_i,
  input  logic [DW-1:0]     txe_i,
  input  logic [DW-1:0]     txe_en_i,
  output logic [SUM_W-1:0]  sum_o
);
  logic [DW-1:0] rxe0_m, txe_m;

  assign rxe0_m = rxe0_i & rxe0_en_i;
  assign txe_m  = txe_i & txe_en_i;

  always_comb begin
    sum_o           = '0;
    sum_o[S_RX_CS]  = |rxe0_m[NUM_EP-1:0];
    sum_o[S_RX_LEN] = |rxe0_m[DW-1:NUM_EP];
    sum_o[S_RX_ZLP] = |(rxe1_i & rxe1_en_i);
    sum_o[S_TX_CS]  = |txe_m[NUM_EP-1:0];
    sum_o[S_TX_LEN] = |txe_m[DW-1:NUM_EP];
  end
endmodule

// File: rtl/qirq_aggregator.sv
module qirq_aggregator
  import qirq_pkg::*;
#(
  parameter int NUM_EP = 16,
  localparam int DW = 2 * NUM_EP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic [NUM_EP-1:0] tx_done_i,
  input  logic [NUM_EP-1:0] rx_done_i,
  input  logic [NUM_EP-1:0] rx_cs_err_i,
  input  logic [NUM_EP-1:0] rx_len_err_i,
  input  logic [NUM_EP-1:0] rx_zlp_err_i,
  input  logic [NUM_EP-1:0] tx_cs_err_i,
  input  logic [NUM_EP-1:0] tx_len_err_i,
  output logic              irq_o
);
  // endpoint 0 has no queue
  localparam logic [NUM_EP-1:0] EP_MASK = ~NUM_EP'(1);

  logic [DW-1:0]     done_q, done_en_q, rxe0_q, rxe0_en_q, txe_q, txe_en_q;
  logic [NUM_EP-1:0] rxe1_q, rxe1_en_q;
  logic [SUM_W-1:0]  sum, sum_en_q;
  logic              src_any;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_addr_e r);
    return reg_we_i && (a == r);
  endfunction

  qirq_w1c_reg #(.W(DW)) u_done (
    .clk_i, .rst_ni,
    .set_i({rx_done_i & EP_MASK, tx_done_i & EP_MASK}),
    .clr_i(reg_wdata_i & {DW{hit(reg_addr_i, A_DONE)}}),
    .q_o  (done_q)
  );

  qirq_w1c_reg #(.W(DW)) u_rxe0 (
    .clk_i, .rst_ni,
    .set_i({rx_len_err_i & EP_MASK, rx_cs_err_i & EP_MASK}),
    .clr_i(reg_wdata_i & {DW{hit(reg_addr_i, A_RXE0)}}),
    .q_o  (rxe0_q)
  );

  qirq_w1c_reg #(.W(NUM_EP)) u_rxe1 (
    .clk_i, .rst_ni,
    .set_i(rx_zlp_err_i & EP_MASK),
    .clr_i(reg_wdata_i[NUM_EP-1:0] & {NUM_EP{hit(reg_addr_i, A_RXE1)}}),
    .q_o  (rxe1_q)
  );

  qirq_w1c_reg #(.W(DW)) u_txe (
    .clk_i, .rst_ni,
    .set_i({tx_len_err_i & EP_MASK, tx_cs_err_i & EP_MASK}),
    .clr_i(reg_wdata_i & {DW{hit(reg_addr_i, A_TXE)}}),
    .q_o  (txe_q)
  );

  qirq_en_reg #(.W(DW)) u_done_en (
    .clk_i, .rst_ni, .we_i(hit(reg_addr_i, A_DONE_EN)),
    .d_i(reg_wdata_i), .q_o(done_en_q));

  qirq_en_reg #(.W(SUM_W)) u_sum_en (
    .clk_i, .rst_ni, .we_i(hit(reg_addr_i, A_SUM_EN)),
    .d_i(reg_wdata_i[SUM_W-1:0]), .q_o(sum_en_q));

  qirq_en_reg #(.W(DW)) u_rxe0_en (
    .clk_i, .rst_ni, .we_i(hit(reg_addr_i, A_RXE0_EN)),
    .d_i(reg_wdata_i), .q_o(rxe0_en_q));

  qirq_en_reg #(.W(NUM_EP)) u_rxe1_en (
    .clk_i, .rst_ni, .we_i(hit(reg_addr_i, A_RXE1_EN)),
    .d_i(reg_wdata_i[NUM_EP-1:0]), .q_o(rxe1_en_q));

  qirq_en_reg #(.W(DW)) u_txe_en (
    .clk_i, .rst_ni, .we_i(hit(reg_addr_i, A_TXE_EN)),
    .d_i(reg_wdata_i), .q_o(txe_en_q));

  qirq_summary #(.NUM_EP(NUM_EP)) u_sum (
    .rxe0_i(rxe0_q), .rxe0_en_i(rxe0_en_q),
    .rxe1_i(rxe1_q), .rxe1_en_i(rxe1_en_q),
    .txe_i(txe_q),   .txe_en_i(txe_en_q),
    .sum_o(sum)
  );

  assign src_any = |(done_q & done_en_q) | |(sum & sum_en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= src_any;
  end

  always_comb begin
    case (reg_addr_e'(reg_addr_i))
      A_DONE:    reg_rdata_o = done_q;
      A_DONE_EN: reg_rdata_o = done_en_q;
      A_SUM:     reg_rdata_o = DW'(sum);
      A_SUM_EN:  reg_rdata_o = DW'(sum_en_q);
      A_RXE0:    reg_rdata_o = rxe0_q;
      A_RXE0_EN: reg_rdata_o = rxe0_en_q;
      A_RXE1:    reg_rdata_o = DW'(rxe1_q);
      A_RXE1_EN: reg_rdata_o = DW'(rxe1_en_q);
      A_TXE:     reg_rdata_o = txe_q;
      A_TXE_EN:  reg_rdata_o = txe_en_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  p_ep0_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q[0] && !done_q[NUM_EP] && !rxe0_q[0] && !rxe0_q[NUM_EP] &&
    !rxe1_q[0] && !txe_q[0] && !txe_q[NUM_EP]);

  p_irq_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_any |=> irq_o);

  p_irq_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_any |=> !irq_o);

  p_sum_txlen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum[S_TX_LEN] |-> (txe_q[DW-1:NUM_EP] != '0));

  p_sum_zlp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxe1_en_q == '0) |-> !sum[S_RX_ZLP]);
endmodule

// File: tb/qirq_aggregator_tb.sv
`timescale 1ns/1ps
module qirq_aggregator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] tx_done = '0, rx_done = '0, rx_cs = '0, rx_len = '0;
  logic [15:0] rx_zlp = '0, tx_cs = '0, tx_len = '0;
  logic        irq;
  int          checks = 0;
  int          failures = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  qirq_aggregator dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tx_done_i(tx_done), .rx_done_i(rx_done),
    .rx_cs_err_i(rx_cs), .rx_len_err_i(rx_len), .rx_zlp_err_i(rx_zlp),
    .tx_cs_err_i(tx_cs), .tx_len_err_i(tx_len),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic pulse(input logic [15:0] txd, input logic [15:0] rxd,
                       input logic [15:0] rcs, input logic [15:0] rln,
                       input logic [15:0] rzl, input logic [15:0] tcs,
                       input logic [15:0] tln);
    @(negedge clk);
    tx_done = txd; rx_done = rxd; rx_cs = rcs; rx_len = rln;
    rx_zlp = rzl; tx_cs = tcs; tx_len = tln;
    @(negedge clk);
    tx_done = '0; rx_done = '0; rx_cs = '0; rx_len = '0;
    rx_zlp = '0; tx_cs = '0; tx_len = '0;
  endtask

  task automatic clear_all();
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd4, 32'hFFFF_FFFF);
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd8, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 10; a++) rd("R1 reg after reset", 4'(a), 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_done_set();
    pulse(16'h0008, 16'h0020, 0, 0, 0, 0, 0);
    rd("R2 done bits", 4'd0, 32'h0020_0008);
    chk("R10 irq low with enables off", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_w1c();
    wr(4'd0, 32'h0000_0000);
    rd("R3 zero write keeps", 4'd0, 32'h0020_0008);
    wr(4'd0, 32'h0000_0008);
    rd("R3 one write clears", 4'd0, 32'h0020_0000);
    wr(4'd0, 32'h0020_0000);
    rd("R3 cleared", 4'd0, 32'h0);
  endtask

  task automatic t_race();
    pulse(16'h0004, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    we = 1'b1; addr = 4'd0; wdata = 32'h0000_0004; tx_done = 16'h0004;
    @(negedge clk);
    we = 1'b0; wdata = '0; tx_done = '0;
    rd("R4 event beats clear", 4'd0, 32'h0000_0004);
    wr(4'd0, 32'h0000_0004);
    rd("R4 later clear works", 4'd0, 32'h0);
  endtask

  task automatic t_ep0();
    pulse(16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0001);
    rd("R5 ep0 done", 4'd0, 32'h0);
    rd("R5 ep0 rx err0", 4'd4, 32'h0);
    rd("R5 ep0 rx err1", 4'd6, 32'h0);
    rd("R5 ep0 tx err", 4'd8, 32'h0);
  endtask

  task automatic t_errors();
    pulse(0, 0, 16'h0002, 16'h0010, 16'h0100, 16'h0400, 16'h8000);
    rd("R6 rx err0 layout", 4'd4, 32'h0010_0002);
    rd("R6 rx err1 layout", 4'd6, 32'h0000_0100);
    rd("R6 tx err layout", 4'd8, 32'h8000_0400);
    rd("R7 summary masked", 4'd2, 32'h0);
    wr(4'd5, 32'h0010_0000);
    rd("R7 summary rx len", 4'd2, 32'h0000_0002);
    wr(4'd7, 32'h0000_0100);
    wr(4'd9, 32'hFFFF_FFFF);
    rd("R7 summary several", 4'd2, 32'h0000_001E);
    wr(4'd5, 32'hFFFF_FFFF);
    rd("R7 summary all", 4'd2, 32'h0000_001F);
    chk("R8 irq off without sum enable", {31'b0, irq}, 32'h0);
    wr(4'd3, 32'h0000_0010);
    chk("R8 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq from summary", {31'b0, irq}, 32'h1);
    wr(4'd8, 32'h8000_0000);
    rd("R6 tx err w1c", 4'd8, 32'h0000_0400);
    rd("R7 tx len cleared", 4'd2, 32'h0000_000F);
    chk("R8 irq still high one cycle", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R8 irq falls", {31'b0, irq}, 32'h0);
    wr(4'd3, 32'h0);
    clear_all();
    rd("R7 summary empty", 4'd2, 32'h0);
  endtask

  task automatic t_enables();
    wr(4'd1, 32'hA5A5_5A5A);
    rd("R9 done enable", 4'd1, 32'hA5A5_5A5A);
    wr(4'd3, 32'hFFFF_FFEB);
    rd("R9 sum enable", 4'd3, 32'h0000_000B);
    wr(4'd7, 32'h1234_5678);
    rd("R9 rx err1 enable", 4'd7, 32'h0000_5678);
    wr(4'd1, 32'h0);
    wr(4'd3, 32'h0);
  endtask

  task automatic t_irq_done();
    wr(4'd1, 32'h0040_0000);
    pulse(0, 16'h0040, 0, 0, 0, 0, 0);
    rd("R2 rx done bit", 4'd0, 32'h0040_0000);
    chk("R8 irq registered delay", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq from done", {31'b0, irq}, 32'h1);
    wr(4'd0, 32'h0040_0000);
    @(negedge clk);
    chk("R8 irq after clear", {31'b0, irq}, 32'h0);
    pulse(16'h0002, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R10 unenabled done no irq", {31'b0, irq}, 32'h0);
    rd("R10 unenabled bit still set", 4'd0, 32'h0000_0002);
    wr(4'd1, 32'h0);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_done_set();
    t_w1c();
    t_race();
    t_ep0();
    t_errors();
    t_enables();
    t_irq_done();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule